// File: doc/BRIEF.md
# Interleaved SECDED Burst-Error Codec

This block protects a block of data words on a serial link whose noise arrives in bursts. The transmit half extends each accepted word with Hamming check bits and an overall parity bit. It stores a whole block of these codewords, then shifts the block out by columns: bit position 0 of every stored codeword, then bit position 1 of every codeword, and so on. The receive half rebuilds the codewords from the bit stream. It then decodes each one on its own and delivers the words in their original order, each with a status code.

Because neighbouring stream bits belong to different codewords, a contiguous burst no longer than the block depth lands at most one flipped bit in any codeword. Single-error correction repairs that bit. A code with minimum distance d detects d-1 flipped bits, and correcting E bits needs distance 2E+1. The check bits and overall parity together give distance 4, so one flip per word is repaired and two flips are flagged. The depth parameter should be set to the longest burst the link is expected to produce.

Top module: `ilv_secded_codec`

## Requirements
- R1: While reset is held and right after it is released, tx_ready is 1 and both ser_valid and rx_valid are 0.
- R2: A codeword has CW = DATA_W + P + 1 bits, where P is the smallest count with 2^P >= DATA_W + P + 1. This gives P = 4 and CW = 13 for 8-bit data. Bit 2^k is a check bit that gives even parity over every position 1..CW-1 whose index has bit k set. The data bits fill the remaining positions from 3 upward, data LSB first. Bit 0 gives even parity over the whole codeword.
- R3: The transmitter accepts a word on each cycle where tx_valid and tx_ready are both high. After the DEPTH-th word of a block is accepted, tx_ready is low and ser_valid is high for exactly CW*DEPTH consecutive cycles, starting the next cycle. tx_ready is high again on the cycle after the last serial bit.
- R4: Serial bit k of a block carries bit floor(k/DEPTH) of the codeword of word k mod DEPTH.
- R5: The receiver takes ser_in on each cycle where ser_in_valid is high. Two cycles after the cycle of the CW*DEPTH-th bit, it raises rx_valid for exactly DEPTH consecutive cycles and presents the words in their original order.
- R6: A word received with no flipped bit comes out with rx_status 00 and its original data.
- R7: A word with exactly one flipped bit, at any position including the overall parity bit, comes out with rx_status 01 and its original data.
- R8: A word with two flipped bits comes out with rx_status 10. The status value 11 is never produced.
- R9: A contiguous burst of up to DEPTH stream bits is fully repaired. A burst of DEPTH+1 bits that starts at stream bit 0 makes word 0 come out with status 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | A data word is offered to the transmitter |
| tx_data | input | DATA_W | Data word to protect |
| tx_ready | output | 1 | Transmitter is filling and will take a word |
| ser_out | output | 1 | Serial bit sent by the transmitter |
| ser_valid | output | 1 | ser_out carries a bit this cycle |
| ser_in | input | 1 | Serial bit arriving at the receiver |
| ser_in_valid | input | 1 | ser_in carries a bit this cycle |
| rx_valid | output | 1 | A decoded word is presented |
| rx_data | output | DATA_W | Decoded (possibly repaired) data word |
| rx_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The serial stream starts the cycle after the last word of a block is accepted and lasts CW*DEPTH cycles. The first decoded word appears two cycles after the cycle that carried the last serial bit, and the words follow on DEPTH back-to-back cycles. The bench samples on the falling edge and keeps a cycle counter that only advances on the rising edge. It logs the counter value when the last word is driven and when each serial bit is present, and compares the start of each output run against those values plus one and plus two. It also checks the run lengths, and it matches the decoded words against a queue filled in block order. The expected status of each word comes from the number of flipped stream bits that the bench's mask places on that word.

// File: rtl/ilv_secded_codec.sv
module ilv_secded_codec #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              ser_out,
  output logic              ser_valid,
  input  logic              ser_in,
  input  logic              ser_in_valid,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic [1:0]        rx_status
);
  function automatic int chk_count(int w);
    int p = 1;
    while ((1 << p) < w + p + 1) p++;
    return p;
  endfunction

  localparam int P  = chk_count(DATA_W);
  localparam int N  = DATA_W + P;
  localparam int CW = N + 1;
  localparam int WW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CB = $clog2(CW);
  localparam int DB = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [WW-1:0] WLAST = WW'(DEPTH - 1);
  localparam logic [CB-1:0] CLAST = CB'(CW - 1);

  function automatic logic [CW-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        c[i[CB-1:0]] = d[j[DB-1:0]];
        j++;
      end
    for (int k = 0; k < P; k++) begin
      logic par;
      int q;
      par = 1'b0;
      for (int i = 1; i <= N; i++)
        if (((i >> k) & 1) == 1) par ^= c[i[CB-1:0]];
      q = 1 << k;
      c[q[CB-1:0]] = par;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [DATA_W+1:0] decode(input logic [CW-1:0] cin);
    logic [CW-1:0] c;
    logic [DATA_W-1:0] d;
    logic [1:0] st;
    logic ov;
    int syn;
    int j;
    c = cin;
    syn = 0;
    for (int i = 1; i <= N; i++)
      if (c[i[CB-1:0]]) syn ^= i;
    ov = ^c;
    if (ov) begin
      if (syn <= N) begin
        c[syn[CB-1:0]] = ~c[syn[CB-1:0]];
        st = 2'b01;
      end else st = 2'b10;
    end else st = (syn != 0) ? 2'b10 : 2'b00;
    d = '0;
    j = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        d[j[DB-1:0]] = c[i[CB-1:0]];
        j++;
      end
    return {st, d};
  endfunction

  logic          sending;
  logic [WW-1:0] tw;
  logic [CB-1:0] tb;
  logic [CW-1:0] tx_mem [DEPTH];

  assign tx_ready  = !sending;
  assign ser_valid = sending;
  assign ser_out   = sending & tx_mem[tw][tb];

  always_ff @(posedge clk)
    if (!sending && tx_valid) tx_mem[tw] <= encode(tx_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      tw      <= '0;
      tb      <= '0;
    end else if (!sending) begin
      if (tx_valid) begin
        if (tw == WLAST) begin
          tw      <= '0;
          sending <= 1'b1;
        end else tw <= tw + WW'(1);
      end
    end else if (tw == WLAST) begin
      tw <= '0;
      if (tb == CLAST) begin
        tb      <= '0;
        sending <= 1'b0;
      end else tb <= tb + CB'(1);
    end else tw <= tw + WW'(1);
  end

  logic          outing;
  logic [WW-1:0] rw, ow;
  logic [CB-1:0] rb;
  logic [CW-1:0] rx_mem [DEPTH];

  always_ff @(posedge clk)
    if (!outing && ser_in_valid) rx_mem[rw][rb] <= ser_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outing    <= 1'b0;
      rw        <= '0;
      rb        <= '0;
      ow        <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_status <= 2'b00;
    end else begin
      rx_valid <= outing;
      if (!outing) begin
        if (ser_in_valid) begin
          if (rw == WLAST) begin
            rw <= '0;
            if (rb == CLAST) begin
              rb     <= '0;
              outing <= 1'b1;
            end else rb <= rb + CB'(1);
          end else rw <= rw + WW'(1);
        end
      end else begin
        {rx_status, rx_data} <= decode(rx_mem[ow]);
        if (ow == WLAST) begin
          ow     <= '0;
          outing <= 1'b0;
        end else ow <= ow + WW'(1);
      end
    end
  end
endmodule

module ilv_secded_codec_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CW     = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              ser_valid,
  input logic              ser_in_valid,
  input logic              rx_valid,
  input logic [1:0]        rx_status
);
  int ser_run;
  int rx_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_run <= 0;
      rx_run  <= 0;
    end else begin
      ser_run <= ser_valid ? ser_run + 1 : 0;
      rx_run  <= rx_valid ? rx_run + 1 : 0;
    end
  end

  AST_SER_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> ser_run == CW * DEPTH);                      // R3
  AST_RX_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> rx_run == DEPTH);                             // R5
  AST_RX_START_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(ser_in_valid, 2));                      // R5
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_status != 2'b11);                                 // R8
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> tx_ready);                                   // R3
endmodule

bind ilv_secded_codec ilv_secded_codec_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .ser_valid(ser_valid),
  .ser_in_valid(ser_in_valid), .rx_valid(rx_valid), .rx_status(rx_status)
);

// File: tb/test_ilv_secded_codec.sv
module test_ilv_secded_codec;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int CW     = 13;
  localparam int NB     = CW * DEPTH;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_ready, ser_out, ser_valid, ser_in, ser_in_valid;
  logic rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic [1:0] rx_status;

  logic [NB-1:0] mask = '0;
  logic [NB-1:0] stream = '0;
  int bitcnt = 0;
  int cyc = 0;
  int nchk = 0, nerr = 0;
  int last_acc = -10, last_ser = -10;
  int ser_run = 0, rx_run = 0;
  bit ser_prev = 0, rx_prev = 0, ready_bad = 0;
  int exp_d[$];
  int exp_s[$];
  logic [DATA_W-1:0] blk [DEPTH];

  always #5 clk = ~clk;

  assign ser_in       = ser_out ^ (ser_valid & mask[bitcnt]);
  assign ser_in_valid = ser_valid;

  ilv_secded_codec #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ilv_secded_codec (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ser_out(ser_out), .ser_valid(ser_valid), .ser_in(ser_in), .ser_in_valid(ser_in_valid),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_status(rx_status)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) bitcnt <= 0;
    else if (ser_valid) bitcnt <= (bitcnt == NB - 1) ? 0 : bitcnt + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_valid) begin
        if (!ser_prev) begin
          check(cyc == last_acc + 1, "R3 stream start", cyc, last_acc + 1);
          ser_run = 0;
          ready_bad = 0;
        end
        ser_run++;
        if (tx_ready) ready_bad = 1;
        stream[bitcnt] = ser_out;
      end else if (ser_prev) begin
        check(ser_run == NB, "R3 stream length", ser_run, NB);
        check(!ready_bad && tx_ready, "R3 ready hold", int'(ready_bad), 0);
      end
      ser_prev = ser_valid;
      if (ser_in_valid) last_ser = cyc;
      if (rx_valid) begin
        if (!rx_prev) check(cyc == last_ser + 2, "R5 output latency", cyc, last_ser + 2);
        rx_run++;
        if (exp_d.size() == 0) check(0, "R5 unexpected word", 1, 0);
        else begin
          int ed, es;
          ed = exp_d.pop_front();
          es = exp_s.pop_front();
          check(rx_status == es[1:0], es == 0 ? "R6 status" : (es == 1 ? "R7 status" : "R8 status"),
                rx_status, es);
          if (es != 2) check(rx_data == ed[DATA_W-1:0], es == 0 ? "R6 data" : "R7 data", rx_data, ed);
        end
      end else if (rx_prev) begin
        check(rx_run == DEPTH, "R5 output count", rx_run, DEPTH);
        rx_run = 0;
      end
      rx_prev = rx_valid;
    end
  end

  task automatic run_block(bit gaps);
    for (int w = 0; w < DEPTH; w++) begin
      int n = 0;
      for (int b = 0; b < CW; b++) n += mask[b * DEPTH + w];
      exp_d.push_back(int'(blk[w]));
      exp_s.push_back(n);
    end
    for (int w = 0; w < DEPTH; w++) begin
      @(negedge clk);
      tx_valid = 0;
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1;
      tx_data = blk[w];
      if (w == DEPTH - 1) last_acc = cyc;
    end
    @(negedge clk);
    tx_valid = 0;
    while (exp_d.size() != 0 || rx_valid || ser_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic random_data();
    for (int w = 0; w < DEPTH; w++) blk[w] = DATA_W'($urandom);
  endtask

  task automatic layout_check(int j, logic [DATA_W-1:0] d, int p0, int p1, int p2, int p3);
    int bad = 0;
    for (int w = 0; w < DEPTH; w++) blk[w] = '0;
    blk[j] = d;
    mask = '0;
    stream = '0;
    run_block(0);
    for (int k = 0; k < NB; k++) begin
      int b = k / DEPTH;
      bit e = (k % DEPTH == j) && (b == p0 || b == p1 || b == p2 || b == p3);
      if (stream[k] != e) bad++;
    end
    check(bad == 0, "R2 R4 codeword bits in column order", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(tx_ready && !ser_valid && !rx_valid, "R1 during reset",
          {tx_ready, ser_valid, rx_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(tx_ready && !ser_valid && !rx_valid, "R1 after reset",
          {tx_ready, ser_valid, rx_valid}, 3'b100);

    // R6: clean blocks, random and extreme data
    random_data(); mask = '0; run_block(1);
    for (int w = 0; w < DEPTH; w++) blk[w] = (w % 2) ? '1 : '0;
    run_block(0);

    // R2 R4: single nonzero word, known code positions
    layout_check(3, 8'h01, 0, 1, 2, 3);
    layout_check(DEPTH - 1, 8'h80, 0, 4, 8, 12);

    // R7: overall parity bit flipped in every word (column 0)
    random_data(); mask = '0;
    for (int w = 0; w < DEPTH; w++) mask[w] = 1'b1;
    run_block(0);

    // R9: bursts of DEPTH bits at random starts
    for (int t = 0; t < 4; t++) begin
      int s = $urandom % (NB - DEPTH + 1);
      random_data(); mask = '0;
      for (int k = s; k < s + DEPTH; k++) mask[k] = 1'b1;
      run_block(1);
    end

    // R9 R8: burst of DEPTH+1 from bit 0, word 0 gets two flips
    random_data(); mask = '0;
    for (int k = 0; k <= DEPTH; k++) mask[k] = 1'b1;
    run_block(0);

    // R7 R8: random zero, one or two flips per word
    for (int t = 0; t < 12; t++) begin
      random_data(); mask = '0;
      for (int w = 0; w < DEPTH; w++) begin
        int n = $urandom % 3;
        int b1 = $urandom % CW;
        int b2 = (b1 + 1 + $urandom % (CW - 1)) % CW;
        if (n >= 1) mask[b1 * DEPTH + w] = 1'b1;
        if (n == 2) mask[b2 * DEPTH + w] = 1'b1;
      end
      run_block(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    check(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule